// File: doc/BRIEF.md
# Dual-Channel Sample Output Formatter

This block takes an in-phase and a quadrature conversion result, each 10 bits wide. It recodes them and presents them on two registered output buses, together with a channel strobe. The clock runs at the output-slot rate, and each sample pair occupies two consecutive slots. A pair is captured in the first slot of each two-slot period.

In parallel presentation, both buses change together in the first slot and hold in the second. In interleaved presentation, the in-phase bus carries the I word in the first slot and the Q word of the same pair in the second slot. The quadrature bus is then driven to all zeros.

The strobe is high in the first slot and low in the second, so it rises once per pair in both modes. A coding input selects offset binary, or two's complement formed by inverting the MSB. Both control inputs pass through a two-flop synchronizer. A mode change takes effect only at a pair boundary.

The slot sequencer has five states:
- ST_IDLE: after reset. It leaves on the first clock to ST_PAR_NEW or ST_MUX_I.
- ST_PAR_NEW: a parallel pair has just loaded. It always moves to ST_PAR_HOLD.
- ST_PAR_HOLD: the second parallel slot.
- ST_MUX_I: the interleaved I slot. It always moves to ST_MUX_Q.
- ST_MUX_Q: the interleaved Q slot.

From ST_PAR_HOLD or ST_MUX_Q the sequencer goes to ST_PAR_NEW when the synchronized mode is high, and to ST_MUX_I when it is low.

Top module: `iq_out_formatter`

## Requirements
- R1: While reset is asserted (rst_n low), out_i, out_q and chan_stb are all zero.
- R2: With par_mode high, one slot after capture out_i equals the coded I word and out_q equals the coded Q word. Both stay unchanged through the following slot.
- R3: With par_mode low, out_i carries the coded I word in the slot where chan_stb is high. It carries the coded Q word of the same pair in the next slot, where chan_stb is low.
- R4: With par_mode low, every bit of out_q is 0.
- R5: Once running, chan_stb alternates every clock: 1 in the first slot of a pair and 0 in the second, in both modes.
- R6: With twos_fmt low, the coded word equals the input (offset binary). With twos_fmt high, the coded word equals the input with bit 9 (the MSB) inverted and bits 8..0 unchanged (two's complement). Bit 0 is the LSB on both buses.
- R7: par_mode and twos_fmt each pass through two flip-flops before use. A new mode value first governs the pair that starts at the second pair boundary after it is applied, when it is applied just after a strobe-high slot begins.
- R8: A pair is captured at the clock edge that starts its strobe-high slot. Input changes during the strobe-high slot have no effect on out_i or out_q in the strobe-low slot that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_mode | input | 1 | 1 = parallel buses, 0 = interleaved on out_i |
| twos_fmt | input | 1 | 1 = two's complement, 0 = offset binary |
| samp_i | input | 10 | In-phase conversion result |
| samp_q | input | 10 | Quadrature conversion result |
| out_i | output | 10 | In-phase (or interleaved) output bus |
| out_q | output | 10 | Quadrature output bus |
| chan_stb | output | 1 | Channel strobe, high in the first slot of each pair |

## Verification
The assertions take for granted that the sequencer's state and the registered outputs start from reset. They also assume the control inputs are asynchronous, so they reason only about the synchronized mode and not the raw pins.

The stimulus changes par_mode, twos_fmt and the samples only at falling edges. It waits several pairs after each table entry before sampling, so that synchronizer latency and any in-flight pair have cleared. The latency and capture-point tests then place their changes just after a strobe-high slot begins, so the expected slot is fixed exactly.

// File: rtl/iq_fmt_pkg.sv
package iq_fmt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PAR_NEW  = 3'd1,
        ST_PAR_HOLD = 3'd2,
        ST_MUX_I    = 3'd3,
        ST_MUX_Q    = 3'd4
    } slot_st_t;

    localparam int CTRL_W = 2;   // {par_mode, twos_fmt}

endpackage

// File: rtl/iq_sync.sv
module iq_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else begin
                    if (s == 0) chain[s] <= d_in;
                    else        chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/iq_coder.sv
module iq_coder #(
    parameter int W = 10
) (
    input  logic [W-1:0] raw,
    input  logic         twos,
    output logic [W-1:0] coded
);
    localparam int MSB = W - 1;

    always_comb begin
        coded      = raw;
        coded[MSB] = raw[MSB] ^ twos;   // offset binary -> two's complement
    end
endmodule

// File: rtl/iq_slot_fsm.sv
module iq_slot_fsm
    import iq_fmt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     par_sel,
    output slot_st_t cur_st,
    output logic     load_par,
    output logic     load_mux,
    output logic     show_q
);
    slot_st_t nxt_st;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_st <= ST_IDLE;
        else        cur_st <= nxt_st;
    end

    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            ST_IDLE, ST_PAR_HOLD, ST_MUX_Q:
                nxt_st = par_sel ? ST_PAR_NEW : ST_MUX_I;
            ST_PAR_NEW:
                nxt_st = ST_PAR_HOLD;
            ST_MUX_I:
                nxt_st = ST_MUX_Q;
            default:
                nxt_st = ST_IDLE;
        endcase
    end

    always_comb begin
        load_par = (nxt_st == ST_PAR_NEW);
        load_mux = (nxt_st == ST_MUX_I);
        show_q   = (nxt_st == ST_MUX_Q);
    end
endmodule

// File: rtl/iq_out_formatter.sv
module iq_out_formatter
    import iq_fmt_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_mode,
    input  logic              twos_fmt,
    input  logic [DATA_W-1:0] samp_i,
    input  logic [DATA_W-1:0] samp_q,
    output logic [DATA_W-1:0] out_i,
    output logic [DATA_W-1:0] out_q,
    output logic              chan_stb
);
    logic [CTRL_W-1:0] ctrl_s;
    logic              par_s;
    logic              twos_s;
    logic [DATA_W-1:0] coded_i;
    logic [DATA_W-1:0] coded_q;
    logic [DATA_W-1:0] q_hold;
    slot_st_t          cur_st;
    logic              load_par;
    logic              load_mux;
    logic              show_q;

    iq_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) ctrl_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({par_mode, twos_fmt}),
        .d_out (ctrl_s)
    );
    assign par_s  = ctrl_s[1];
    assign twos_s = ctrl_s[0];

    iq_coder #(.W(DATA_W)) code_i_i (.raw(samp_i), .twos(twos_s), .coded(coded_i));
    iq_coder #(.W(DATA_W)) code_q_i (.raw(samp_q), .twos(twos_s), .coded(coded_q));

    iq_slot_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .par_sel  (par_s),
        .cur_st   (cur_st),
        .load_par (load_par),
        .load_mux (load_mux),
        .show_q   (show_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_i    <= '0;
            out_q    <= '0;
            q_hold   <= '0;
            chan_stb <= 1'b0;
        end else begin
            chan_stb <= load_par | load_mux;
            if (load_par) begin
                out_i  <= coded_i;
                out_q  <= coded_q;
                q_hold <= coded_q;
            end else if (load_mux) begin
                out_i  <= coded_i;
                out_q  <= '0;
                q_hold <= coded_q;
            end else if (show_q) begin
                out_i  <= q_hold;
                out_q  <= '0;
            end
        end
    end
endmodule

// File: rtl/iq_out_formatter_chk.sv
module iq_out_formatter_chk
    import iq_fmt_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] out_i,
    input logic [DATA_W-1:0] out_q,
    input logic              chan_stb,
    input slot_st_t          cur_st
);
    // R5: strobe alternates once running
    a_r5_stb_falls: assert property (@(posedge clk) disable iff (!rst_n)
        chan_stb |=> !chan_stb);
    a_r5_stb_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_stb && cur_st != ST_IDLE) |=> chan_stb);

    // R4: quadrature bus is zero through interleaved slots
    a_r4_q_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_MUX_I || cur_st == ST_MUX_Q) |-> out_q == '0);

    // R2: parallel words hold through the second slot
    a_r2_par_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_PAR_NEW) |=> ($stable(out_i) && $stable(out_q)));

    // R3: strobe is high in the I slot and low in the Q slot
    a_r3_stb_i_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_MUX_I) |-> chan_stb);
    a_r3_stb_q_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_MUX_Q) |-> !chan_stb);

    // R7: a pair always completes its second slot before any mode change
    a_r7_pair_whole: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_MUX_I) |=> (cur_st == ST_MUX_Q));
endmodule

bind iq_out_formatter iq_out_formatter_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_i    (out_i),
    .out_q    (out_q),
    .chan_stb (chan_stb),
    .cur_st   (cur_st)
);

// File: tb/iq_out_formatter_tb_top.sv
module iq_out_formatter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 10;
    localparam int NVEC       = 8;

    // {mode, fmt, i[9:0], q[9:0]}
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 10'h000, 10'h3FF},
        {1'b1, 1'b1, 10'h200, 10'h1FF},
        {1'b0, 1'b0, 10'h155, 10'h2AA},
        {1'b0, 1'b1, 10'h3FF, 10'h001},
        {1'b1, 1'b1, 10'h000, 10'h3FF},
        {1'b0, 1'b0, 10'h200, 10'h200},
        {1'b1, 1'b0, 10'h123, 10'h321},
        {1'b0, 1'b1, 10'h080, 10'h37F}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         par_mode = 1'b0;
    logic         twos_fmt = 1'b0;
    logic [W-1:0] samp_i = '0;
    logic [W-1:0] samp_q = '0;
    logic [W-1:0] out_i;
    logic [W-1:0] out_q;
    logic         chan_stb;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iq_out_formatter dut_i (
        .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .twos_fmt(twos_fmt),
        .samp_i(samp_i), .samp_q(samp_q),
        .out_i(out_i), .out_q(out_q), .chan_stb(chan_stb)
    );

    function automatic logic [W-1:0] enc(input logic [W-1:0] v, input logic tw);
        return tw ? {~v[W-1], v[W-2:0]} : v;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wait_stb_high();
        for (int k = 0; k < 4; k++) begin
            if (chan_stb === 1'b1) break;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] ei, eq;
        step(3);
        // R1: reset state
        chk("R1 out_i", out_i, '0);
        chk("R1 out_q", out_q, '0);
        chk("R1 chan_stb", {9'd0, chan_stb}, '0);
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            par_mode = VEC[v][21];
            twos_fmt = VEC[v][20];
            samp_i   = VEC[v][19:10];
            samp_q   = VEC[v][9:0];
            step(8);
            wait_stb_high();
            ei = enc(samp_i, twos_fmt);
            eq = enc(samp_q, twos_fmt);
            chk("R5 strobe high", {9'd0, chan_stb}, 10'd1);
            chk("R6 R2 R3 out_i first slot", out_i, ei);
            chk(par_mode ? "R2 out_q" : "R4 out_q", out_q, par_mode ? eq : '0);
            step(1);
            chk("R5 strobe low", {9'd0, chan_stb}, 10'd0);
            chk(par_mode ? "R2 out_i hold" : "R3 out_i Q word", out_i, par_mode ? ei : eq);
            chk(par_mode ? "R2 out_q hold" : "R4 out_q", out_q, par_mode ? eq : '0);
        end

        // R8: capture point in interleaved mode
        par_mode = 1'b0; twos_fmt = 1'b0;
        samp_i = 10'h111; samp_q = 10'h222;
        step(8);
        wait_stb_high();
        samp_i = 10'h333; samp_q = 10'h044;
        step(1);
        chk("R8 out_i keeps captured Q", out_i, 10'h222);
        step(1);
        chk("R8 new pair I", out_i, 10'h333);
        step(1);
        chk("R8 new pair Q", out_i, 10'h044);

        // R7: mode latency through synchronizer and pair boundary
        samp_i = 10'h0F0; samp_q = 10'h30F;
        step(6);
        wait_stb_high();
        par_mode = 1'b1;
        step(2);
        chk("R7 still interleaved", out_q, '0);
        step(2);
        chk("R7 now parallel", out_q, 10'h30F);
        chk("R7 strobe", {9'd0, chan_stb}, 10'd1);

        // R6: format latency (two slots unaffected)
        wait_stb_high();
        twos_fmt = 1'b1;
        step(6);
        wait_stb_high();
        chk("R6 twos out_i", out_i, 10'h2F0);
        chk("R6 twos out_q", out_q, 10'h10F);

        // R1: reset again mid-run
        rst_n = 1'b0;
        step(1);
        chk("R1 re-reset out_i", out_i, '0);
        chk("R1 re-reset stb", {9'd0, chan_stb}, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule